// File: doc/BRIEF.md
# Half-Duplex DMA Packet Buffer

This block sits on a dedicated path between a DMA engine's bus and a peripheral, apart from the processor bus. It holds one packet at a time and moves it in a single direction. Software starts a packet by giving a direction and a byte count. In transmit, the DMA side writes the bytes and the peripheral takes whole 16-byte entries. In receive, the peripheral supplies whole entries and the DMA side reads the bytes back out.

The storage is 512 bytes, organised as 32 entries of 16 bytes (128 bits). A DMA transaction carries 1, 2, 4 or 8 bytes. These are packed little-endian into the current entry at a byte pointer, or unpacked from it. The pointer moves to the next entry once the entry is used up or the packet ends. The block does not drop data: a full store or an empty store holds the DMA handshake back. A new packet cannot be configured until the current one has completed, so a receive always waits for the end of a transmit.

Top module: `hdx_pkt_fifo`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `cfg_err`, `full`, `dma_ack` and `per_tx_valid` are 0, and `empty` is 1.
- R2: A DMA request is rejected when `dma_size` is not 1, 2, 4 or 8, or when no packet is active. A rejected request gives `dma_err`=1 in the same cycle, gives no `dma_ack`, and changes no state.
- R3: In transmit (`cfg_dir`=0), byte i of `dma_wdata` goes to byte lane (pointer + i) of the current entry, and lane 0 sits in bits 7:0. `per_tx_data` presents an entry only after all 16 of its lanes are filled or the packet's last byte has been written.
- R4: In receive (`cfg_dir`=1), `dma_rdata` byte i equals byte (pointer + i) of the oldest entry for i < `dma_size`. The bytes above `dma_size` are 0.
- R5: In transmit, while 32 entries are held (`full`=1), a legal request gets no `dma_ack`, and it is accepted after the peripheral takes an entry.
- R6: In receive, while no entry is held, a legal request gets neither `dma_ack` nor `dma_err`.
- R7: A configuration request while `busy`=1 is ignored. `busy` and `dir_rx` stay unchanged, and `cfg_err` becomes 1 and stays 1 until reset.
- R8: When the remaining byte count is zero (and, in transmit, the store has drained), `done` is 1 for exactly one cycle, and `busy` is 0 in that same cycle.
- R9: A request whose size exceeds the remaining byte count, or that would run past lane 15 of the current entry, is rejected with `dma_err`=1.
- R10: In receive, `per_rx_ready` is 1 only while fewer than ceil(count/16) entries have been accepted and the store is not full.
- R11: A configuration with a byte count of 0 is ignored and sets `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Start-packet request |
| cfg_dir | input | 1 | 0 transmit, 1 receive |
| cfg_len | input | 12 | Packet byte count |
| dma_req | input | 1 | DMA transaction request |
| dma_size | input | 4 | Transaction byte count (1, 2, 4, 8) |
| dma_wdata | input | 64 | Transmit bytes, lane 0 in bits 7:0 |
| dma_ack | output | 1 | Transaction accepted this cycle |
| dma_err | output | 1 | Transaction rejected this cycle |
| dma_rdata | output | 64 | Receive bytes, lane 0 in bits 7:0 |
| per_tx_valid | output | 1 | A completed entry is available to the peripheral |
| per_tx_ready | input | 1 | Peripheral takes the entry |
| per_tx_data | output | 128 | Oldest entry |
| per_rx_valid | input | 1 | Peripheral offers an entry |
| per_rx_ready | output | 1 | Block accepts the entry |
| per_rx_data | input | 128 | Entry from the peripheral |
| busy | output | 1 | A packet is active |
| dir_rx | output | 1 | Direction of the active packet |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Sticky configuration error |
| full | output | 1 | 32 entries held |
| empty | output | 1 | No entry held |

## Verification
A wrong byte pointer puts bytes in the wrong lanes. This is seen on `per_tx_data` as soon as the first entry closes, or on `dma_rdata` in the same cycle as the read. A wrong remaining count moves the point at which `dma_err` or `done` appears, so it shows within one transaction of the packet's end. A wrong entry count either stalls the handshake early or lets it through at 32 entries. Both are seen in the first cycle the store reaches its limit.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
    typedef enum logic { DIR_TX = 1'b0, DIR_RX = 1'b1 } dir_e;

    function automatic logic size_legal(input logic [3:0] sz);
        return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
    endfunction
endpackage

// File: rtl/hdx_store.sv
module hdx_store #(
    parameter int DEPTH = 32,
    parameter int EB    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [EB-1:0]   wr_be,
    input  logic [EB*8-1:0] wr_data,
    input  logic            commit,
    input  logic            pop,
    output logic [EB*8-1:0] rd_data,
    output logic            full,
    output logic            empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = EB * 8;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;
    logic [EW-1:0] mem [DEPTH];

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            if (commit) s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
            if (pop)    s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
            s_d.cnt = s_q.cnt + CW'(commit) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < EB; b++) begin
                if (wr_be[b]) mem[s_q.wp][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    assign rd_data = mem[s_q.rp];
    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && commit) |-> pop);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/hdx_ctrl.sv
module hdx_ctrl
    import hdx_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int EB    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic             cfg_dir,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             dma_req,
    input  logic [3:0]       dma_size,
    input  logic             full,
    input  logic             empty,
    input  logic             per_tx_ready,
    input  logic             per_rx_valid,
    output logic             dma_ack,
    output logic             dma_err,
    output logic [$clog2(EB)-1:0] bptr,
    output logic             wr_en,
    output logic             commit,
    output logic             pop,
    output logic             clr,
    output logic             per_tx_valid,
    output logic             per_rx_ready,
    output logic             busy,
    output logic             dir_rx,
    output logic             done,
    output logic             cfg_err
);
    localparam int PW = $clog2(EB);

    typedef struct packed {
        logic             busy;
        dir_e             dir;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] rx_left;
        logic [PW-1:0]    bptr;
        logic             done;
        logic             cfg_err;
    } st_t;

    st_t s_d, s_q;
    logic [PW:0]    span;
    logic [LEN_W:0] ent_need;
    logic           fits, legal, close, is_tx, rx_push, tx_pop;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        is_tx    = (s_q.dir == DIR_TX);
        span     = (PW+1)'(s_q.bptr) + (PW+1)'(dma_size);
        fits     = (span <= (PW+1)'(EB)) && (LEN_W'(dma_size) <= s_q.rem);
        legal    = s_q.busy && dma_req && size_legal(dma_size) && fits;
        dma_err  = dma_req && !(s_q.busy && size_legal(dma_size) && fits);
        dma_ack  = legal && (is_tx ? !full : !empty);
        close    = (span == (PW+1)'(EB)) || (LEN_W'(dma_size) == s_q.rem);
        per_tx_valid = s_q.busy && is_tx && !empty;
        per_rx_ready = s_q.busy && !is_tx && (s_q.rx_left != '0) && !full;
        tx_pop   = per_tx_valid && per_tx_ready;
        rx_push  = per_rx_ready && per_rx_valid;
        wr_en    = (dma_ack && is_tx) || rx_push;
        commit   = (dma_ack && is_tx && close) || rx_push;
        pop      = tx_pop || (dma_ack && !is_tx && close);
        clr      = 1'b0;
        ent_need = ({1'b0, cfg_len} + (LEN_W+1)'(EB - 1)) >> PW;

        if (dma_ack) begin
            s_d.rem  = s_q.rem - LEN_W'(dma_size);
            s_d.bptr = close ? '0 : span[PW-1:0];
        end
        if (rx_push) s_d.rx_left = s_q.rx_left - 1'b1;

        if (s_q.busy) begin
            if (cfg_valid) s_d.cfg_err = 1'b1;
            if ((s_q.rem == '0) && (!is_tx || empty)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end else if (cfg_valid) begin
            if (cfg_len == '0) begin
                s_d.cfg_err = 1'b1;
            end else begin
                clr         = 1'b1;
                s_d.busy    = 1'b1;
                s_d.dir     = dir_e'(cfg_dir);
                s_d.rem     = cfg_len;
                s_d.rx_left = LEN_W'(ent_need);
                s_d.bptr    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bptr    = s_q.bptr;
    assign busy    = s_q.busy;
    assign dir_rx  = (s_q.dir == DIR_RX);
    assign done    = s_q.done;
    assign cfg_err = s_q.cfg_err;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    assert_cfg_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && cfg_valid && s_q.rem != '0) |=> (s_q.busy && $stable(s_q.dir) && s_q.cfg_err));
    assert_rem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !dma_ack) |=> $stable(s_q.rem));
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cfg_err |=> s_q.cfg_err);
endmodule

// File: rtl/hdx_pkt_fifo.sv
module hdx_pkt_fifo #(
    parameter int LEN_W = 12,
    parameter int DEPTH = 32,
    parameter int EB    = 16,
    parameter int DW    = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic             cfg_dir,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             dma_req,
    input  logic [3:0]       dma_size,
    input  logic [DW-1:0]    dma_wdata,
    output logic             dma_ack,
    output logic             dma_err,
    output logic [DW-1:0]    dma_rdata,
    output logic             per_tx_valid,
    input  logic             per_tx_ready,
    output logic [EB*8-1:0]  per_tx_data,
    input  logic             per_rx_valid,
    output logic             per_rx_ready,
    input  logic [EB*8-1:0]  per_rx_data,
    output logic             busy,
    output logic             dir_rx,
    output logic             done,
    output logic             cfg_err,
    output logic             full,
    output logic             empty
);
    localparam int EW = EB * 8;
    localparam int PW = $clog2(EB);
    localparam int DB = DW / 8;

    logic [PW-1:0] bptr;
    logic          wr_en, commit, pop, clr;
    logic [EB-1:0] size_be, wr_be;
    logic [EW-1:0] wr_data, rd_data;
    logic [DW-1:0] rd_low;

    hdx_ctrl #(.LEN_W(LEN_W), .EB(EB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_dir(cfg_dir),
        .cfg_len(cfg_len), .dma_req(dma_req), .dma_size(dma_size),
        .full(full), .empty(empty), .per_tx_ready(per_tx_ready),
        .per_rx_valid(per_rx_valid), .dma_ack(dma_ack), .dma_err(dma_err),
        .bptr(bptr), .wr_en(wr_en), .commit(commit), .pop(pop), .clr(clr),
        .per_tx_valid(per_tx_valid), .per_rx_ready(per_rx_ready),
        .busy(busy), .dir_rx(dir_rx), .done(done), .cfg_err(cfg_err)
    );

    hdx_store #(.DEPTH(DEPTH), .EB(EB)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .commit(commit), .pop(pop), .rd_data(rd_data),
        .full(full), .empty(empty)
    );

    always_comb begin
        for (int b = 0; b < EB; b++) size_be[b] = (b < int'(dma_size));
        wr_be   = dir_rx ? '1 : (size_be << bptr);
        wr_data = dir_rx ? per_rx_data : (EW'(dma_wdata) << {bptr, 3'b000});
        rd_low  = DW'(rd_data >> {bptr, 3'b000});
        for (int b = 0; b < DB; b++)
            dma_rdata[b*8 +: 8] = (b < int'(dma_size)) ? rd_low[b*8 +: 8] : 8'h00;
    end

    assign per_tx_data = rd_data;

    assert_ack_err_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_ack && dma_err));
    assert_idle_no_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dma_ack);
endmodule

// File: tb/sim_hdx_pkt_fifo.sv
module sim_hdx_pkt_fifo;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 0, cfg_dir = 0;
    logic [11:0] cfg_len = '0;
    logic dma_req = 0;
    logic [3:0] dma_size = '0;
    logic [63:0] dma_wdata = '0;
    logic dma_ack, dma_err;
    logic [63:0] dma_rdata;
    logic per_tx_valid, per_tx_ready = 0;
    logic [127:0] per_tx_data;
    logic per_rx_valid = 0, per_rx_ready;
    logic [127:0] per_rx_data = '0;
    logic busy, dir_rx, done, cfg_err, full, empty;

    int checks = 0, failures = 0;
    logic a_q, e_q;
    logic [63:0] r_q;
    logic [7:0] eb [0:31];
    int pos = 0;

    always #2 clk = ~clk;

    hdx_pkt_fifo u0 (.*);

    // size[68:65], data[64:1], expected error[0]
    localparam logic [68:0] VEC [0:8] = '{
        {4'd1, 64'h0000_0000_0000_0011, 1'b0},
        {4'd3, 64'h0000_0000_0000_00EE, 1'b1},
        {4'd2, 64'h0000_0000_0000_3322, 1'b0},
        {4'd4, 64'h0000_0000_7766_5544, 1'b0},
        {4'd8, 64'hFFEE_DDCC_BBAA_9988, 1'b0},
        {4'd2, 64'h0000_0000_0000_5A5A, 1'b1},
        {4'd1, 64'h0000_0000_0000_00A0, 1'b0},
        {4'd0, 64'h0000_0000_0000_0000, 1'b1},
        {4'd8, 64'hB7B6_B5B4_B3B2_B1B0, 1'b0}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    task automatic cfg(input logic d, input logic [11:0] len);
        @(negedge clk); cfg_valid = 1; cfg_dir = d; cfg_len = len;
        @(posedge clk); #1 cfg_valid = 0;
    endtask

    task automatic dma(input logic [3:0] s, input logic [63:0] d);
        @(negedge clk); dma_req = 1; dma_size = s; dma_wdata = d;
        #1 a_q = dma_ack; e_q = dma_err; r_q = dma_rdata;
        @(posedge clk); #1 dma_req = 0;
    endtask

    task automatic tx_take();
        @(negedge clk); per_tx_ready = 1;
        @(posedge clk); #1 per_tx_ready = 0;
    endtask

    task automatic rx_give(input logic [127:0] d);
        @(negedge clk); per_rx_valid = 1; per_rx_data = d;
        @(posedge clk); #1 per_rx_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] exp_e;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0); chk("R1 empty", empty, 1); chk("R1 full", full, 0);
        chk("R1 cfg_err", cfg_err, 0); chk("R1 done", done, 0); chk("R1 tx_valid", per_tx_valid, 0);

        // R2 request while idle is rejected
        dma(4'd4, 64'h1234);
        chk("R2 idle err", e_q, 1); chk("R2 idle ack", a_q, 0);

        // R11 zero-length configuration
        cfg(1'b0, 12'd0);
        chk("R11 busy", busy, 0); chk("R11 cfg_err", cfg_err, 1);
        do_reset();

        // transmit packet of 24 bytes, walked from the vector table (R2 R3 R9)
        cfg(1'b0, 12'd24);
        chk("R3 busy", busy, 1); chk("R3 dir", dir_rx, 0);
        for (int i = 0; i < 9; i++) begin
            dma(VEC[i][68:65], VEC[i][64:1]);
            chk(VEC[i][0] ? "R2/R9 err" : "R3 err", e_q, VEC[i][0]);
            chk("R2 ack", a_q, !VEC[i][0]);
            if (a_q) begin
                for (int b = 0; b < int'(VEC[i][68:65]); b++) begin
                    eb[pos] = VEC[i][1 + b*8 +: 8];
                    pos++;
                end
            end
        end
        @(negedge clk);
        exp_e = '0;
        for (int b = 0; b < 16; b++) exp_e[b*8 +: 8] = eb[b];
        chk("R3 tx_valid", per_tx_valid, 1);
        chk("R3 entry0", per_tx_data, exp_e);

        // R7 configuration during an active packet
        cfg(1'b1, 12'd16);
        chk("R7 cfg_err", cfg_err, 1); chk("R7 busy", busy, 1); chk("R7 dir", dir_rx, 0);

        tx_take();
        exp_e = '0;
        for (int b = 0; b < 8; b++) exp_e[b*8 +: 8] = eb[16 + b];
        chk("R3 entry1 low", {64'h0, per_tx_data[63:0]}, exp_e);
        tx_take();
        @(posedge clk); #1;
        chk("R8 done", done, 1); chk("R8 busy", busy, 0);
        @(posedge clk); #1;
        chk("R8 done single", done, 0);

        // receive packet of 20 bytes (R4 R6 R9 R10)
        do_reset();
        cfg(1'b1, 12'd20);
        chk("R10 ready", per_rx_ready, 1);
        dma(4'd4, '0);
        chk("R6 ack", a_q, 0); chk("R6 err", e_q, 0);
        rx_give(128'h0F0E0D0C_0B0A0908_07060504_03020100);
        rx_give(128'h1F1E1D1C_1B1A1918_17161514_13121110);
        @(negedge clk);
        chk("R10 ready after budget", per_rx_ready, 0);
        dma(4'd4, '0); chk("R4 rd4", r_q, 64'h0000_0000_0302_0100);
        dma(4'd8, '0); chk("R4 rd8", r_q, 64'h0B0A_0908_0706_0504);
        dma(4'd2, '0); chk("R4 rd2a", r_q, 64'h0D0C);
        dma(4'd2, '0); chk("R4 rd2b", r_q, 64'h0F0E);
        dma(4'd8, '0); chk("R9 over remaining", e_q, 1);
        dma(4'd4, '0); chk("R4 next entry", r_q, 64'h1312_1110); chk("R4 ack", a_q, 1);
        @(posedge clk); #1;
        chk("R8 rx done", done, 1); chk("R8 rx busy", busy, 0);

        // R5 full stall in transmit
        cfg(1'b0, 12'd520);
        for (int i = 0; i < 64; i++) begin
            dma(4'd8, 64'(i));
            if (!a_q) begin
                failures++;
                $display("FAIL R5 fill ack actual=0 expected=1 at %0d", i);
            end
        end
        checks++;
        @(negedge clk);
        chk("R5 full", full, 1);
        dma(4'd8, 64'hDEAD);
        chk("R5 stalled", a_q, 0); chk("R5 no err", e_q, 0);
        chk("R5 head intact", per_tx_data, {64'd1, 64'd0});
        tx_take();
        dma(4'd8, 64'hBEEF);
        chk("R5 resume", a_q, 1);
        @(negedge clk); per_tx_ready = 1;
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
        chk("R8 drained done", done, 1);
        per_tx_ready = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule